// File: doc/BRIEF.md
# Single-Precision Float to 32-bit Integer Converter

This block takes a packed single-precision floating-point word and converts it to a 32-bit integer. A select input chooses an unsigned or a two's-complement result. A 2-bit rounding-mode input controls rounding. A truncate input forces round-toward-zero whatever the mode input says. Values that do not fit and NaNs saturate to fixed limits and raise the invalid flag. A result that lost fractional bits raises inexact. A subnormal operand raises the input-denormal flag.

The conversion is combinational, with one register stage at the output. A word presented with `in_valid` high appears on `result` and the flags at the next rising clock edge, together with `out_valid`. The output register holds its value while `in_valid` is low. The exponent decides which of three paths is taken: saturate (biased exponent at least 159), shift-and-round (126 to 158), or below-one-half (under 126). Rounding works by adding a mode-dependent increment to the left-aligned 32-bit remainder. The integer part is bumped when that addition carries out.

Top module: `fti_convert`

## Requirements
- R1: A word accepted with in_valid high sets out_valid, result and flags at the next rising edge. With in_valid low, out_valid falls and result and flags hold. Reset clears all outputs to zero.
- R2: flag_denorm is set exactly when the exponent field (bits 30:23) is zero and the fraction (bits 22:0) is nonzero. Such an input yields 0 with inexact, except under the directed-mode rules of R9.
- R3: A biased exponent of 159 or more (bits 30:23) sets invalid. Unsigned mode then gives 0 for a negative sign (bit 31) and 0xFFFFFFFF otherwise. Signed mode gives 0x80000000 for a negative sign and 0x7FFFFFFF otherwise.
- R4: In unsigned mode a NaN (exponent all ones, fraction nonzero) is treated as positive and gives 0xFFFFFFFF with invalid. In signed mode a NaN keeps its sign bit.
- R5: rmode encoding: 00 = nearest with ties to even, 01 = toward +infinity, 10 = toward -infinity, 11 = toward zero. A directed mode rounds the magnitude up only when it points away from zero for the operand's sign.
- R6: In unsigned mode a negative input whose rounded magnitude is nonzero gives 0 with invalid. A negative input whose rounded magnitude is zero gives 0 without invalid.
- R7: In signed mode a rounded magnitude above 0x7FFFFFFF (positive) or above 0x80000000 (negative) clamps to that limit with invalid. Otherwise the magnitude is negated for a negative input.
- R8: Outside the below-one-half path, inexact is set when fractional bits were discarded and no invalid was raised, and never together with invalid.
- R9: Below one half (biased exponent under 126), the result is 0 with inexact for a nonzero input. Toward +infinity on a positive input gives 1. Toward -infinity on a negative input gives 0xFFFFFFFF in signed mode, and 0 with invalid in unsigned mode.
- R10: Inputs that are exact integers in range convert with no flags (for example 100.0 gives 100, and 0x4F7FFFFF gives 0xFFFFFF00 unsigned).
- R11: With trunc high the rmode input is ignored and rounding is toward zero, so the magnitude is never rounded up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is valid this cycle |
| in_bits | input | 32 | Packed single-precision operand |
| signed_sel | input | 1 | 1 = signed result, 0 = unsigned result |
| rmode | input | 2 | Rounding mode, encoded as in R5 |
| trunc | input | 1 | Force round toward zero |
| out_valid | output | 1 | Result registered from an accepted word |
| result | output | 32 | Converted integer |
| flag_invalid | output | 1 | Saturation or negative-to-unsigned |
| flag_inexact | output | 1 | Fractional bits were discarded |
| flag_denorm | output | 1 | Operand was subnormal |

## Verification
On every cycle the assertions check the following: the one-cycle valid relation, the denormal flag against the operand's fields, and invalid on every saturating exponent. They also check that unsigned conversion of a negative non-NaN gives zero, that signed conversion of a positive gives a non-negative result, that inexact and invalid never meet outside the below-one-half path, and that truncation never produces a rounding carry. These properties cannot pin down exact values. The directed scenarios supply them: ties-to-even behaviour, each directed mode on both signs, the signed limits at plus and minus two to the thirty-first, and the below-one-half corner results. A model-driven sweep across the shift range covers the remaining rounding cases.

// File: rtl/fti_pkg.sv
`timescale 1ns/1ps
package fti_pkg;
  // Rounding mode encoding shared by datapath and checks
  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_UP      = 2'b01,
    RM_DOWN    = 2'b10,
    RM_ZERO    = 2'b11
  } fti_rmode_e;

  // Which conversion path an operand takes, chosen by its exponent
  typedef enum logic [1:0] {
    PATH_SMALL = 2'b00,
    PATH_MID   = 2'b01,
    PATH_SAT   = 2'b10
  } fti_path_e;
endpackage

// File: rtl/fti_classify.sv
`timescale 1ns/1ps
module fti_classify
  import fti_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 32,
  localparam int FW   = 1 + EXP_W + MAN_W,
  localparam int SH_W = $clog2(INT_W + 1)
) (
  input  logic [FW-1:0]    bits_i,
  input  logic             signed_i,
  output logic             sign_o,
  output fti_path_e        path_o,
  output logic [SH_W-1:0]  shift_o,
  output logic [INT_W-1:0] sig_o,
  output logic             nonzero_o,
  output logic             denorm_o
);
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int TOP_EXP = BIAS + INT_W - 1;
  localparam int SAT_EXP = BIAS + INT_W;
  localparam int LOW_EXP = BIAS - 1;
  localparam int PAD_W   = INT_W - 1 - MAN_W;

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             is_nan;

  assign exp_f  = bits_i[FW-2 -: EXP_W];
  assign man_f  = bits_i[MAN_W-1:0];
  assign is_nan = (&exp_f) && (|man_f);

  // Unsigned conversion treats any NaN as positive
  assign sign_o = bits_i[FW-1] && (signed_i || !is_nan);

  function automatic fti_path_e pick_path(input logic [EXP_W-1:0] e);
    if (int'(e) >= SAT_EXP) return PATH_SAT;
    if (int'(e) >= LOW_EXP) return PATH_MID;
    return PATH_SMALL;
  endfunction

  assign path_o    = pick_path(exp_f);
  // Only meaningful on the mid path, where it lies in 0..INT_W
  assign shift_o   = SH_W'(TOP_EXP - int'(exp_f));
  // Hidden one restored at the top bit, fraction below it
  assign sig_o     = {1'b1, man_f, {PAD_W{1'b0}}};
  assign nonzero_o = |bits_i[FW-2:0];
  assign denorm_o  = (exp_f == '0) && (|man_f);
endmodule

// File: rtl/fti_align.sv
`timescale 1ns/1ps
module fti_align #(
  parameter int INT_W = 32,
  localparam int SH_W = $clog2(INT_W + 1)
) (
  input  logic [INT_W-1:0] sig_i,
  input  logic [SH_W-1:0]  shift_i,
  output logic [INT_W-1:0] whole_o,
  output logic [INT_W-1:0] frac_o
);
  // Shift a double-width window: the upper half is the integer part,
  // the lower half keeps the discarded bits left-aligned.
  function automatic logic [2*INT_W-1:0] split(input logic [INT_W-1:0] s,
                                               input logic [SH_W-1:0]  n);
    return {s, {INT_W{1'b0}}} >> n;
  endfunction

  logic [2*INT_W-1:0] window;
  assign window  = split(sig_i, shift_i);
  assign whole_o = window[2*INT_W-1:INT_W];
  assign frac_o  = window[INT_W-1:0];
endmodule

// File: rtl/fti_round.sv
`timescale 1ns/1ps
module fti_round
  import fti_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  logic [INT_W-1:0] whole_i,
  input  logic [INT_W-1:0] frac_i,
  input  fti_rmode_e       mode_i,
  input  logic             sign_i,
  output logic [INT_W-1:0] whole_o,
  output logic             carry_o,
  output logic             blocked_o
);
  localparam logic [INT_W-1:0] HALF = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] ONE  = INT_W'(1);

  // Increment added to the remainder; a carry-out means round up
  function automatic logic [INT_W-1:0] pick_incr(input fti_rmode_e m,
                                                 input logic s,
                                                 input logic lsb);
    case (m)
      RM_NEAREST: return lsb ? HALF : HALF - ONE;
      RM_UP:      return s ? '0 : '1;
      RM_DOWN:    return s ? '1 : '0;
      default:    return '0;
    endcase
  endfunction

  logic [INT_W:0] sum;
  logic           at_top;

  assign sum       = {1'b0, frac_i} + {1'b0, pick_incr(mode_i, sign_i, whole_i[0])};
  assign carry_o   = sum[INT_W];
  assign at_top    = &whole_i;
  assign blocked_o = carry_o && at_top;
  assign whole_o   = (carry_o && !at_top) ? whole_i + ONE : whole_i;
endmodule

// File: rtl/fti_finish.sv
`timescale 1ns/1ps
module fti_finish
  import fti_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  fti_path_e        path_i,
  input  logic             signed_i,
  input  logic             sign_i,
  input  logic             nonzero_i,
  input  fti_rmode_e       mode_i,
  input  logic [INT_W-1:0] whole_i,
  input  logic [INT_W-1:0] frac_i,
  input  logic             blocked_i,
  output logic [INT_W-1:0] value_o,
  output logic             invalid_o,
  output logic             inexact_o
);
  localparam logic [INT_W-1:0] POS_MAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] NEG_MIN = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] ONE     = INT_W'(1);

  logic [INT_W-1:0] signed_limit;
  assign signed_limit = sign_i ? NEG_MIN : POS_MAX;

  function automatic logic [INT_W-1:0] sat_value(input logic sgn_mode, input logic s);
    if (sgn_mode) return s ? NEG_MIN : POS_MAX;
    return s ? '0 : '1;
  endfunction

  always_comb begin
    value_o   = '0;
    invalid_o = 1'b0;
    inexact_o = 1'b0;
    case (path_i)
      PATH_SAT: begin
        invalid_o = 1'b1;
        value_o   = sat_value(signed_i, sign_i);
      end
      PATH_MID: begin
        if (signed_i) begin
          if (whole_i > signed_limit) begin
            invalid_o = 1'b1;
            value_o   = signed_limit;
          end else begin
            value_o   = sign_i ? -whole_i : whole_i;
            inexact_o = |frac_i;
          end
        end else begin
          value_o   = whole_i;
          invalid_o = blocked_i;
          if (sign_i && (|whole_i)) begin
            value_o   = '0;
            invalid_o = 1'b1;
          end
          inexact_o = (|frac_i) && !invalid_o;
        end
      end
      default: begin
        if (nonzero_i) begin
          inexact_o = 1'b1;
          if (mode_i == RM_UP && !sign_i) begin
            value_o = ONE;
          end else if (mode_i == RM_DOWN && sign_i) begin
            if (signed_i) value_o = '1;
            else          invalid_o = 1'b1;
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/fti_convert.sv
`timescale 1ns/1ps
module fti_convert
  import fti_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 32,
  localparam int FW   = 1 + EXP_W + MAN_W,
  localparam int SH_W = $clog2(INT_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [FW-1:0]    in_bits,
  input  logic             signed_sel,
  input  logic [1:0]       rmode,
  input  logic             trunc,
  output logic             out_valid,
  output logic [INT_W-1:0] result,
  output logic             flag_invalid,
  output logic             flag_inexact,
  output logic             flag_denorm
);
  fti_rmode_e       mode_eff;
  logic             sign_w;
  fti_path_e        path_w;
  logic [SH_W-1:0]  shift_w;
  logic [INT_W-1:0] sig_w;
  logic             nonzero_w;
  logic             denorm_w;
  logic [INT_W-1:0] whole_w;
  logic [INT_W-1:0] frac_w;
  logic [INT_W-1:0] rounded_w;
  logic             round_carry;
  logic             round_blocked;
  logic [INT_W-1:0] res_c;
  logic             inv_c;
  logic             inx_c;

  assign mode_eff = trunc ? RM_ZERO : fti_rmode_e'(rmode);

  fti_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_classify (
    .bits_i   (in_bits),
    .signed_i (signed_sel),
    .sign_o   (sign_w),
    .path_o   (path_w),
    .shift_o  (shift_w),
    .sig_o    (sig_w),
    .nonzero_o(nonzero_w),
    .denorm_o (denorm_w)
  );

  fti_align #(.INT_W(INT_W)) u_align (
    .sig_i  (sig_w),
    .shift_i(shift_w),
    .whole_o(whole_w),
    .frac_o (frac_w)
  );

  fti_round #(.INT_W(INT_W)) u_round (
    .whole_i  (whole_w),
    .frac_i   (frac_w),
    .mode_i   (mode_eff),
    .sign_i   (sign_w),
    .whole_o  (rounded_w),
    .carry_o  (round_carry),
    .blocked_o(round_blocked)
  );

  fti_finish #(.INT_W(INT_W)) u_finish (
    .path_i   (path_w),
    .signed_i (signed_sel),
    .sign_i   (sign_w),
    .nonzero_i(nonzero_w),
    .mode_i   (mode_eff),
    .whole_i  (rounded_w),
    .frac_i   (frac_w),
    .blocked_i(round_blocked),
    .value_o  (res_c),
    .invalid_o(inv_c),
    .inexact_o(inx_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      result       <= '0;
      flag_invalid <= 1'b0;
      flag_inexact <= 1'b0;
      flag_denorm  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result       <= res_c;
        flag_invalid <= inv_c;
        flag_inexact <= inx_c;
        flag_denorm  <= denorm_w;
      end
    end
  end

  // ---------------- assertions ----------------
  logic in_is_nan;
  assign in_is_nan = (&in_bits[FW-2 -: EXP_W]) && (|in_bits[MAN_W-1:0]);

  p_valid_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_denorm_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> flag_denorm == $past((in_bits[FW-2 -: EXP_W] == '0) && (|in_bits[MAN_W-1:0])));

  p_sat_invalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && path_w == PATH_SAT) |=> flag_invalid);

  p_neg_unsigned_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !signed_sel && in_bits[FW-1] && !in_is_nan) |=> (result == '0));

  p_pos_signed_nonneg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && signed_sel && !in_bits[FW-1]) |=> !result[INT_W-1]);

  p_inexact_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && path_w != PATH_SMALL) |-> !(inv_c && inx_c));

  p_small_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && path_w == PATH_SMALL) |-> (res_c == '0 || res_c == INT_W'(1) || res_c == '1));

  p_trunc_no_carry_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && trunc) |-> !round_carry);
endmodule

// File: tb/tb_fti_convert.sv
`timescale 1ns/1ps
module tb_fti_convert;
  localparam logic [1:0] NEAR = 2'b00;
  localparam logic [1:0] UP   = 2'b01;
  localparam logic [1:0] DOWN = 2'b10;
  localparam logic [1:0] ZERO = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_bits;
  logic        signed_sel;
  logic [1:0]  rmode;
  logic        trunc;
  logic        out_valid;
  logic [31:0] result;
  logic        flag_invalid, flag_inexact, flag_denorm;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fti_convert dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
    .signed_sel(signed_sel), .rmode(rmode), .trunc(trunc),
    .out_valid(out_valid), .result(result), .flag_invalid(flag_invalid),
    .flag_inexact(flag_inexact), .flag_denorm(flag_denorm)
  );

  // Flags are bundled {invalid, inexact, denorm}
  task automatic check(input string tag, input logic [34:0] act, input logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got result=%h flags=%b, expected result=%h flags=%b",
               tag, act[34:3], act[2:0], exp[34:3], exp[2:0]);
    end
  endtask

  // Independent reference: integer part and fraction via 64-bit arithmetic
  task automatic model(input logic [31:0] f, input logic sg, input logic [1:0] rm,
                       input logic tr, output logic [31:0] r, output logic [2:0] fl);
    int e; logic s; logic [23:0] full; logic [63:0] ip, fr, half, mag;
    logic up, inv, inx, den; logic [1:0] m;
    m = tr ? ZERO : rm;
    e = int'(f[30:23]); s = f[31];
    den = (e == 0) && (f[22:0] != 0);
    inv = 0; inx = 0; r = 0; up = 0;
    if (!sg && e == 255 && f[22:0] != 0) s = 0;
    if (e >= 159) begin
      inv = 1;
      if (sg) r = s ? 32'h80000000 : 32'h7fffffff;
      else    r = s ? 32'h0 : 32'hffffffff;
    end else if (e >= 126) begin
      full = {1'b1, f[22:0]};
      if (e >= 150) begin ip = 64'(full) << (e - 150); fr = 0; half = 0; end
      else begin
        ip = 64'(full) >> (150 - e);
        fr = 64'(full) & ((64'd1 << (150 - e)) - 64'd1);
        half = 64'd1 << (149 - e);
      end
      case (m)
        NEAR: up = (fr != 0) && ((fr > half) || (fr == half && ip[0]));
        UP:   up = !s && fr != 0;
        DOWN: up = s && fr != 0;
        default: up = 0;
      endcase
      mag = ip + (up ? 64'd1 : 64'd0);
      if (sg) begin
        if (mag > (s ? 64'h80000000 : 64'h7fffffff)) begin
          inv = 1; r = s ? 32'h80000000 : 32'h7fffffff;
        end else begin
          r = s ? 32'(-mag) : mag[31:0]; inx = (fr != 0);
        end
      end else begin
        if (mag > 64'hffffffff) begin inv = 1; r = 32'hffffffff; end
        else if (s && mag != 0) begin inv = 1; r = 0; end
        else begin r = mag[31:0]; inx = (fr != 0); end
      end
    end else if (e != 0 || f[22:0] != 0) begin
      inx = 1;
      if (m == UP && !s) r = 1;
      else if (m == DOWN && s) begin
        if (sg) r = 32'hffffffff; else inv = 1;
      end
    end
    fl = {inv, inx, den};
  endtask

  task automatic run(input logic [31:0] f, input logic sg, input logic [1:0] rm, input logic tr);
    @(negedge clk);
    in_bits = f; signed_sel = sg; rmode = rm; trunc = tr; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_val(input string tag, input logic [31:0] f, input logic sg,
                            input logic [1:0] rm, input logic tr,
                            input logic [31:0] er, input logic [2:0] ef);
    run(f, sg, rm, tr);
    check(tag, {result, flag_invalid, flag_inexact, flag_denorm}, {er, ef});
  endtask

  task automatic t_reset;
    check("R1 reset state", {result, flag_invalid, flag_inexact, flag_denorm}, 35'd0);
    check("R1 reset out_valid", {34'd0, out_valid}, 35'd0);
  endtask

  task automatic t_latency;
    @(negedge clk);
    in_bits = 32'h42C80000; signed_sel = 1'b0; rmode = NEAR; trunc = 1'b0; in_valid = 1'b1;
    #2;
    check("R1 no output before edge", {34'd0, out_valid}, 35'd0);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 output after one edge", {result, out_valid, flag_inexact, flag_denorm},
          {32'd100, 3'b100});
    @(negedge clk);
    check("R1 hold when idle", {result, out_valid, flag_invalid, flag_inexact},
          {32'd100, 3'b000});
  endtask

  task automatic t_saturate;
    expect_val("R3 2^32 unsigned", 32'h4F800000, 0, NEAR, 0, 32'hFFFFFFFF, 3'b100);
    expect_val("R3 2^32 signed",   32'h4F800000, 1, NEAR, 0, 32'h7FFFFFFF, 3'b100);
    expect_val("R3 -inf unsigned", 32'hFF800000, 0, NEAR, 0, 32'h00000000, 3'b100);
    expect_val("R3 -inf signed",   32'hFF800000, 1, NEAR, 0, 32'h80000000, 3'b100);
    expect_val("R4 -NaN unsigned", 32'hFFC00000, 0, ZERO, 0, 32'hFFFFFFFF, 3'b100);
    expect_val("R4 -NaN signed",   32'hFFC00000, 1, ZERO, 0, 32'h80000000, 3'b100);
  endtask

  task automatic t_rounding;
    expect_val("R5 1.5 nearest", 32'h3FC00000, 0, NEAR, 0, 32'd2, 3'b010);
    expect_val("R5 1.5 up",      32'h3FC00000, 0, UP,   0, 32'd2, 3'b010);
    expect_val("R5 1.5 down",    32'h3FC00000, 0, DOWN, 0, 32'd1, 3'b010);
    expect_val("R5 1.5 zero",    32'h3FC00000, 0, ZERO, 0, 32'd1, 3'b010);
    expect_val("R5 2.5 tie even", 32'h40200000, 0, NEAR, 0, 32'd2, 3'b010);
    expect_val("R5 -2.5 nearest", 32'hC0200000, 1, NEAR, 0, 32'hFFFFFFFE, 3'b010);
    expect_val("R5 -2.5 up",      32'hC0200000, 1, UP,   0, 32'hFFFFFFFE, 3'b010);
    expect_val("R5 -2.5 down",    32'hC0200000, 1, DOWN, 0, 32'hFFFFFFFD, 3'b010);
    expect_val("R5 0.5 tie to 0", 32'h3F000000, 0, NEAR, 0, 32'd0, 3'b010);
    expect_val("R5 0.75 nearest", 32'h3F400000, 0, NEAR, 0, 32'd1, 3'b010);
  endtask

  task automatic t_trunc;
    expect_val("R11 1.75 trunc nearest", 32'h3FE00000, 0, NEAR, 1, 32'd1, 3'b010);
    expect_val("R11 1.75 trunc up",      32'h3FE00000, 0, UP,   1, 32'd1, 3'b010);
    expect_val("R11 -1.75 trunc down",   32'hBFE00000, 1, DOWN, 1, 32'hFFFFFFFF, 3'b010);
  endtask

  task automatic t_unsigned_neg;
    expect_val("R6 -2.5 unsigned",   32'hC0200000, 0, NEAR, 0, 32'd0, 3'b100);
    expect_val("R6 -2^31 unsigned",  32'hCF000000, 0, NEAR, 0, 32'd0, 3'b100);
    expect_val("R6 -0.75 toward 0",  32'hBF400000, 0, ZERO, 0, 32'd0, 3'b010);
    expect_val("R8 -1.0 unsigned no inexact", 32'hBF800000, 0, NEAR, 0, 32'd0, 3'b100);
  endtask

  task automatic t_signed_limits;
    expect_val("R7 2^31 signed clamp",  32'h4F000000, 1, NEAR, 0, 32'h7FFFFFFF, 3'b100);
    expect_val("R7 -2^31 signed exact", 32'hCF000000, 1, NEAR, 0, 32'h80000000, 3'b000);
    expect_val("R7 below 2^31 exact",   32'h4EFFFFFF, 1, NEAR, 0, 32'h7FFFFF80, 3'b000);
    expect_val("R7 beyond -2^31 clamp", 32'hCF000001, 1, NEAR, 0, 32'h80000000, 3'b100);
    expect_val("R10 2^31 unsigned",     32'h4F000000, 0, NEAR, 0, 32'h80000000, 3'b000);
  endtask

  task automatic t_small;
    expect_val("R9 0.25 nearest",          32'h3E800000, 0, NEAR, 0, 32'd0, 3'b010);
    expect_val("R9 0.25 up",               32'h3E800000, 1, UP,   0, 32'd1, 3'b010);
    expect_val("R9 -0.25 signed down",     32'hBE800000, 1, DOWN, 0, 32'hFFFFFFFF, 3'b010);
    expect_val("R9 -0.25 unsigned down",   32'hBE800000, 0, DOWN, 0, 32'd0, 3'b110);
    expect_val("R9 -0.25 up",              32'hBE800000, 1, UP,   0, 32'd0, 3'b010);
    expect_val("R9 -0 down",               32'h80000000, 1, DOWN, 0, 32'd0, 3'b000);
  endtask

  task automatic t_denorm;
    expect_val("R2 tiny denorm nearest",   32'h00000001, 0, NEAR, 0, 32'd0, 3'b011);
    expect_val("R2 tiny denorm up",        32'h00000001, 1, UP,   0, 32'd1, 3'b011);
    expect_val("R2 neg denorm signed dn",  32'h80000001, 1, DOWN, 0, 32'hFFFFFFFF, 3'b011);
    expect_val("R2 neg denorm unsigned dn", 32'h80000001, 0, DOWN, 0, 32'd0, 3'b111);
    expect_val("R2 zero not denorm",       32'h00000000, 0, NEAR, 0, 32'd0, 3'b000);
  endtask

  task automatic t_exact;
    expect_val("R10 100.0",      32'h42C80000, 1, NEAR, 0, 32'd100, 3'b000);
    expect_val("R10 1.0",        32'h3F800000, 0, UP,   0, 32'd1, 3'b000);
    expect_val("R10 0xFFFFFF00", 32'h4F7FFFFF, 0, NEAR, 0, 32'hFFFFFF00, 3'b000);
  endtask

  task automatic t_sweep;
    logic [31:0] st, f, er; logic [2:0] ef;
    st = 32'h1D2C3B4A;
    for (int i = 0; i < 3000; i++) begin
      st = st ^ (st << 13); st = st ^ (st >> 17); st = st ^ (st << 5);
      f = st;
      if (i % 2 == 0) f[30:23] = 8'(120 + (st[31:24] % 45));
      model(f, st[0], st[2:1], st[3] & st[4], er, ef);
      run(f, st[0], st[2:1], st[3] & st[4]);
      check("R8 R10 sweep vs model", {result, flag_invalid, flag_inexact, flag_denorm}, {er, ef});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_bits = '0; signed_sel = 1'b0; rmode = NEAR; trunc = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_latency();
    t_saturate();
    t_rounding();
    t_trunc();
    t_unsigned_neg();
    t_signed_limits();
    t_small();
    t_denorm();
    t_exact();
    t_sweep();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule